// File: doc/BRIEF.md
# Attribute Text-Mode Pixel Colour Generator

This block turns the pixel and line counters of a display timing generator into a 6-bit colour for an 80-column by 25-row text screen. Each character cell is 9 pixels wide and 16 lines tall. For the cell under the counters, the block presents one address that serves both the character-code memory and the attribute memory. It then looks up one glyph row in a font memory, using the character code and the line within the cell. It also reads the palette entry that the attribute byte selects. Each palette entry carries a foreground colour, a background colour and a blink flag.

Two independent hardware cursors can be drawn over the text. Each cursor can be a full block or an underline, and each can blink or stay steady. A frame pulse from the timing generator drives a shared blink phase. All four memories are synchronous with one cycle of read latency. The block pipelines their reads so that each colour leaves a fixed three clocks after its counters arrive. Sync generation and the processor write path sit outside the block.

Top module: `glyph_color_gen`

## Requirements
- R1: While rstN is low, and after its release until a visible pixel has passed through the pipeline, pixColor is 0.
- R2: cellAddr is combinationally (lineY/16)*80 + pixX/9. pixColor is registered and shows the colour for the counters presented three rising edges earlier.
- R3: fontAddr is {character code, lineY%16} with the code in the upper 8 bits. Bit 7 of fontData is the leftmost pixel, and sub-column c (0..7) uses bit 7-c. A set bit draws the foreground colour and a clear bit draws the background colour.
- R4: Sub-column 8 of every cell (the ninth pixel) draws the background colour when no cursor covers it.
- R5: palAddr equals the attribute byte. palData holds the blink flag in bit 12, the foreground colour in bits 11:6 and the background colour in bits 5:0. pixColor carries red in bits 5:4, green in 3:2 and blue in 1:0.
- R6: A 5-bit counter advances on each frameTick pulse. While its top bit is 1, an entry whose blink flag is set draws its background colour where the foreground colour would appear.
- R7: When active is low, pixColor is 0 three edges later.
- R8: An enabled block cursor whose curCol and curRow match the cell swaps foreground and background over the whole cell.
- R9: An enabled underline cursor (curUnder=1) swaps colours only on lines 14 and 15 of the matching cell.
- R10: A cursor with curBlink=1 is hidden while the blink counter's top bit is 1. A cursor with curBlink=0 stays visible.
- R11: The two cursors have independent position, shape, blink and enable settings. Where both cover the same pixel, colours are swapped once.
- R12: For the last cell (pixX 719, lineY 399), cellAddr is 1999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| pixX | input | 10 | Pixel counter within the visible line |
| lineY | input | 9 | Visible line counter |
| active | input | 1 | High while the counters are inside the visible area |
| frameTick | input | 1 | One-cycle pulse per frame, advances blink phase |
| curEn | input | 2 | Enable per cursor |
| curUnder | input | 2 | Per cursor: 1 = underline, 0 = block |
| curBlink | input | 2 | Per cursor: 1 = blinking |
| curCol | input | 2x7 | Cursor column per cursor |
| curRow | input | 2x5 | Cursor row per cursor |
| cellAddr | output | 11 | Address to character and attribute memories |
| charData | input | 8 | Character code, one cycle after cellAddr |
| attrData | input | 8 | Attribute byte, one cycle after cellAddr |
| fontAddr | output | 12 | Glyph row address |
| fontData | input | 8 | Glyph row bits, one cycle after fontAddr |
| palAddr | output | 8 | Palette entry index |
| palData | input | 13 | Palette entry, one cycle after palAddr |
| pixColor | output | 6 | RRGGBB colour |

## Verification
The in-RTL properties check four things on every cycle:
- the blanking rule;
- that a ninth-column pixel without a cursor carries the background field of the palette entry read for it;
- that a blinking entry shows only its background in the off phase;
- that the blink counter steps once per frame pulse and the cell address stays in range.

Other behaviour can only be shown by the bench's scenarios against a reference model. This covers glyph bit ordering, correct palette field selection, and the placement of block and underline cursors. It also covers the hiding of blinking cursors while steady ones remain, and overlap of the two cursors.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int COLS       = 80;
  localparam int ROWS       = 25;
  localparam int CELL_W     = 9;
  localparam int CELL_H     = 16;
  localparam int GLYPH_BITS = 8;
  localparam int COLOR_W    = 6;
  localparam int CODE_W     = 8;
  localparam int NCUR       = 2;
  localparam int XW      = $clog2(COLS * CELL_W);
  localparam int YW      = $clog2(ROWS * CELL_H);
  localparam int CELL_AW = $clog2(COLS * ROWS);
  localparam int CW      = $clog2(COLS);
  localparam int RW      = $clog2(ROWS);
  localparam int SCW     = $clog2(CELL_W);
  localparam int SRW     = $clog2(CELL_H);
  localparam int BSW     = $clog2(GLYPH_BITS);
  localparam int FONT_AW = CODE_W + SRW;
  localparam int PAL_W   = 2 * COLOR_W + 1;

  // strobes from control to datapath, aligned with font/palette read data
  typedef struct packed {
    logic           live;
    logic           padCol;
    logic [BSW-1:0] bitSel;
    logic           curHit;
    logic           blinkOff;
  } pixCtl_t;
endpackage

// File: rtl/glyph_ctrl.sv
module glyph_ctrl
  import glyph_pkg::*;
#(
  parameter int BLINK_BITS = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [XW-1:0]             pixX,
  input  logic [YW-1:0]             lineY,
  input  logic                      active,
  input  logic                      frameTick,
  input  logic [NCUR-1:0]           curEn,
  input  logic [NCUR-1:0]           curUnder,
  input  logic [NCUR-1:0]           curBlink,
  input  logic [NCUR-1:0][CW-1:0]   curCol,
  input  logic [NCUR-1:0][RW-1:0]   curRow,
  output logic [CELL_AW-1:0]        cellAddr,
  output logic [SRW-1:0]            fontRow,
  output pixCtl_t                   ctl
);
  logic [XW-1:0] colIdx, subCol;
  logic [YW-1:0] rowIdx, subRow;
  logic [BLINK_BITS-1:0] blinkCnt;
  logic blinkOff;
  logic [NCUR-1:0] hitVec;
  logic s1Live, s1Hit;
  logic [SCW-1:0] s1SubCol;
  logic [SRW-1:0] s1SubRow;

  assign colIdx   = pixX / XW'(CELL_W);
  assign subCol   = pixX % XW'(CELL_W);
  assign rowIdx   = lineY / YW'(CELL_H);
  assign subRow   = lineY % YW'(CELL_H);
  assign cellAddr = CELL_AW'(rowIdx) * CELL_AW'(COLS) + CELL_AW'(colIdx);
  assign blinkOff = blinkCnt[BLINK_BITS-1];
  assign fontRow  = s1SubRow;

  for (genvar g = 0; g < NCUR; g++) begin : g_cursor
    assign hitVec[g] = curEn[g] && (colIdx == XW'(curCol[g])) && (rowIdx == YW'(curRow[g]))
                       && (!curUnder[g] || (subRow >= YW'(CELL_H - 2)))
                       && !(curBlink[g] && blinkOff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blinkCnt <= '0;
      s1Live   <= 1'b0;
      s1Hit    <= 1'b0;
      s1SubCol <= '0;
      s1SubRow <= '0;
      ctl      <= '0;
    end else begin
      if (frameTick) blinkCnt <= blinkCnt + 1'b1;
      s1Live   <= active;
      s1Hit    <= |hitVec;
      s1SubCol <= SCW'(subCol);
      s1SubRow <= SRW'(subRow);
      ctl.live     <= s1Live;
      ctl.padCol   <= (s1SubCol >= SCW'(GLYPH_BITS));
      ctl.bitSel   <= BSW'(s1SubCol);
      ctl.curHit   <= s1Hit;
      ctl.blinkOff <= blinkOff;
    end
  end

  AST_CELL_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (pixX < XW'(COLS * CELL_W) && lineY < YW'(ROWS * CELL_H)) |-> cellAddr < CELL_AW'(COLS * ROWS)); // R12
  AST_BLINK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> blinkCnt == BLINK_BITS'($past(blinkCnt) + 1'b1)); // R6
endmodule

// File: rtl/glyph_dpath.sv
module glyph_dpath
  import glyph_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pixCtl_t              ctl,
  input  logic [SRW-1:0]       fontRow,
  input  logic [CODE_W-1:0]    charData,
  input  logic [7:0]           attrData,
  input  logic [GLYPH_BITS-1:0] fontData,
  input  logic [PAL_W-1:0]     palData,
  output logic [FONT_AW-1:0]   fontAddr,
  output logic [7:0]           palAddr,
  output logic [COLOR_W-1:0]   pixColor
);
  logic [COLOR_W-1:0] fgCol, bgCol, fgShown, nextColor;
  logic blinkEn, pixOn;
  logic [BSW-1:0] bitIdx;

  assign fontAddr = {charData, fontRow};
  assign palAddr  = attrData;
  assign blinkEn  = palData[PAL_W-1];
  assign fgCol    = palData[2*COLOR_W-1:COLOR_W];
  assign bgCol    = palData[COLOR_W-1:0];
  assign fgShown  = (blinkEn && ctl.blinkOff) ? bgCol : fgCol;
  assign bitIdx   = BSW'(GLYPH_BITS - 1) - ctl.bitSel;
  assign pixOn    = !ctl.padCol && fontData[bitIdx];

  always_comb begin
    if (!ctl.live)                nextColor = '0;
    else if (pixOn ^ ctl.curHit)  nextColor = fgShown;
    else                          nextColor = bgCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixColor <= '0;
    else       pixColor <= nextColor;
  end

  AST_PAD_BG: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.live && ctl.padCol && !ctl.curHit) |-> pixColor == $past(palData[COLOR_W-1:0])); // R4
  AST_BLINK_HIDE: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.live && ctl.blinkOff && palData[PAL_W-1]) |-> pixColor == $past(palData[COLOR_W-1:0])); // R6
endmodule

// File: rtl/glyph_color_gen.sv
module glyph_color_gen
  import glyph_pkg::*;
#(
  parameter int BLINK_BITS = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [XW-1:0]           pixX,
  input  logic [YW-1:0]           lineY,
  input  logic                    active,
  input  logic                    frameTick,
  input  logic [NCUR-1:0]         curEn,
  input  logic [NCUR-1:0]         curUnder,
  input  logic [NCUR-1:0]         curBlink,
  input  logic [NCUR-1:0][CW-1:0] curCol,
  input  logic [NCUR-1:0][RW-1:0] curRow,
  output logic [CELL_AW-1:0]      cellAddr,
  input  logic [CODE_W-1:0]       charData,
  input  logic [7:0]              attrData,
  output logic [FONT_AW-1:0]      fontAddr,
  input  logic [GLYPH_BITS-1:0]   fontData,
  output logic [7:0]              palAddr,
  input  logic [PAL_W-1:0]        palData,
  output logic [COLOR_W-1:0]      pixColor
);
  pixCtl_t ctl;
  logic [SRW-1:0] fontRow;

  glyph_ctrl #(.BLINK_BITS(BLINK_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .pixX(pixX), .lineY(lineY), .active(active),
    .frameTick(frameTick), .curEn(curEn), .curUnder(curUnder), .curBlink(curBlink),
    .curCol(curCol), .curRow(curRow), .cellAddr(cellAddr), .fontRow(fontRow), .ctl(ctl)
  );

  glyph_dpath i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fontRow(fontRow), .charData(charData),
    .attrData(attrData), .fontData(fontData), .palData(palData),
    .fontAddr(fontAddr), .palAddr(palAddr), .pixColor(pixColor)
  );

  AST_BLANK_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(active, 3) |-> pixColor == '0); // R7
endmodule

// File: tb/test_glyph_color_gen.sv
module test_glyph_color_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] pixX = '0;
  logic [8:0] lineY = '0;
  logic active = 1'b0;
  logic frameTick = 1'b0;
  logic [1:0] curEn = '0, curUnder = '0, curBlink = '0;
  logic [1:0][6:0] curCol = '0;
  logic [1:0][4:0] curRow = '0;
  logic [10:0] cellAddr;
  logic [7:0] charData = '0, attrData = '0, fontData = '0;
  logic [11:0] fontAddr;
  logic [7:0] palAddr;
  logic [12:0] palData = '0;
  logic [5:0] pixColor;
  int nChecks = 0, nFails = 0, frameCnt = 0;

  always #10 clk = ~clk;

  glyph_color_gen i_glyph_color_gen (
    .clk(clk), .rstN(rstN), .pixX(pixX), .lineY(lineY), .active(active),
    .frameTick(frameTick), .curEn(curEn), .curUnder(curUnder), .curBlink(curBlink),
    .curCol(curCol), .curRow(curRow), .cellAddr(cellAddr), .charData(charData),
    .attrData(attrData), .fontAddr(fontAddr), .fontData(fontData),
    .palAddr(palAddr), .palData(palData), .pixColor(pixColor)
  );

  function automatic logic [7:0] charFn(input int a); return 8'(a * 37 + 11); endfunction
  function automatic logic [7:0] attrFn(input int a); return 8'(a * 53 + 7); endfunction
  function automatic logic [7:0] fontFn(input int a); return 8'((a * 29) ^ (a >> 3)); endfunction
  function automatic logic [12:0] palFn(input logic [7:0] i);
    return {i[7], i[5:0], i[5:0] ^ 6'h15};
  endfunction

  // bench memories: one-cycle synchronous reads
  always_ff @(posedge clk) begin
    charData <= charFn(int'(cellAddr));
    attrData <= attrFn(int'(cellAddr));
    fontData <= fontFn(int'(fontAddr));
    palData  <= palFn(palAddr);
  end

  function automatic logic [5:0] expColor(input int x, input int y);
    int col, sc, row, sr, a;
    logic [7:0] fb;
    logic [12:0] p;
    logic [5:0] fg, bg;
    logic off, on, hit;
    col = x / 9; sc = x % 9; row = y / 16; sr = y % 16;
    a = row * 80 + col;
    fb = fontFn(int'(charFn(a)) * 16 + sr);
    p = palFn(attrFn(a));
    off = (frameCnt % 32) >= 16;
    bg = p[5:0];
    fg = (p[12] && off) ? bg : p[11:6];
    on = (sc < 8) && fb[7 - sc];
    hit = 1'b0;
    for (int g = 0; g < 2; g++)
      if (curEn[g] && col == int'(curCol[g]) && row == int'(curRow[g]) &&
          (!curUnder[g] || sr >= 14) && !(curBlink[g] && off)) hit = 1'b1;
    return (on ^ hit) ? fg : bg;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pix(input int x, input int y, input string tag);
    @(negedge clk);
    pixX = 10'(x); lineY = 9'(y); active = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check($sformatf("%s x=%0d y=%0d", tag, x, y), int'(pixColor), int'(expColor(x, y)));
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frameTick = 1'b1;
      @(negedge clk) frameTick = 1'b0;
      frameCnt++;
    end
  endtask

  localparam int NV = 10;
  localparam int VX[NV] = '{0, 3, 7, 100, 250, 361, 500, 630, 700, 715};
  localparam int VY[NV] = '{0, 5, 15, 33, 120, 200, 255, 310, 388, 17};

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state while counters are live
    @(negedge clk); active = 1'b1; pixX = 10'd40; lineY = 9'd40;
    repeat (4) @(posedge clk);
    @(negedge clk); check("R1 in reset", int'(pixColor), 0);
    rstN = 1'b1; active = 1'b0;
    @(negedge clk); check("R1 after release", int'(pixColor), 0);

    // R2 R3 R5: vector table
    for (int v = 0; v < NV; v++) pix(VX[v], VY[v], "R2 R3 R5 table");
    // R3: one full cell row-span
    for (int x = 18; x < 27; x++) pix(x, 50, "R3 glyph row");
    // R4: ninth column
    for (int c = 0; c < 6; c++) pix(c * 9 + 8, 70 + c * 13, "R4 pad column");

    // R7: blanking
    @(negedge clk); pixX = 10'd100; lineY = 9'd33; active = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R7 blank", int'(pixColor), 0);

    // R6: palette blink off phase, then back on
    frames(16);
    for (int x = 0; x < 45; x++) pix(x, 20 + (x % 16), "R6 blink off");
    frames(16);
    for (int x = 0; x < 18; x++) pix(x, 20 + (x % 16), "R6 blink on");

    // R8: steady block cursor 0 at column 3 row 1
    @(negedge clk); curEn = 2'b01; curUnder = 2'b00; curBlink = 2'b00;
    curCol[0] = 7'd3; curRow[0] = 5'd1;
    for (int y = 16; y < 32; y += 5) for (int x = 27; x < 36; x++) pix(x, y, "R8 block cursor");
    pix(36, 20, "R8 beside cursor");

    // R9 R11: underline cursor 1 at column 4 row 1
    @(negedge clk); curEn = 2'b11; curUnder = 2'b10; curCol[1] = 7'd4; curRow[1] = 5'd1;
    for (int y = 28; y < 32; y++) for (int x = 36; x < 45; x += 2) pix(x, y, "R9 underline");
    // R11: overlap in the same cell
    @(negedge clk); curCol[1] = 7'd3;
    for (int x = 27; x < 36; x++) pix(x, 31, "R11 overlap");
    pix(30, 20, "R11 block only rows");

    // R10: cursor 0 blinks, cursor 1 steady underline at column 4
    @(negedge clk); curBlink = 2'b01; curCol[1] = 7'd4;
    frames(16);
    for (int x = 27; x < 36; x++) pix(x, 22, "R10 blink cursor hidden");
    for (int x = 36; x < 45; x++) pix(x, 30, "R10 steady cursor shown");
    frames(16);
    for (int x = 27; x < 36; x += 2) pix(x, 22, "R10 blink cursor shown");

    // R12: last cell
    @(negedge clk); curEn = 2'b00; pixX = 10'd719; lineY = 9'd399; active = 1'b1;
    #1 check("R12 last cell address", int'(cellAddr), 1999);
    pix(719, 399, "R12 last pixel");
    pix(711, 384, "R12 last cell body");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule